// File: doc/BRIEF.md
# Random-Number Peripheral Control Core

This block is the register-facing core of a random-number peripheral. A plain 32-bit register bus (one-cycle write strobe, one-cycle read strobe, combinational read data) reaches a control register, a status register, a read-only data register and two configuration registers: one for noise control and one for health tests. Entropy arrives on an abstract noise port as a word plus a valid strobe. A divided sampling tick gates that port, and accepted words go into a small FIFO that the data register drains.

The core sequences enable, a self-clearing conditional reset of the conditioning logic, and a sticky configuration lock. It raises clock-error and seed-error flags. A seed error comes in one of two kinds. A recoverable one is cleaned up by the core itself: it flushes the FIFO, keeps generating, and leaves only the interrupt flag set. A hard one stops generation until software runs the conditional reset. A late seed error reaches software as a zero data word. Genuine zero noise words are therefore dropped, so a zero never passes for valid data.

Top module: `rng_ctrl_core`

## Requirements
- R1: After reset, control (0x00), status (0x04), noise control (0x0C) and health-test (0x10) all read 0.
- R2: Status bit 0 (data ready) is 1 only while control bit 2 (enable) is 1, no hard seed error is active and the FIFO holds a word. Each data-register (0x08) read while ready pops one word, oldest first.
- R3: A noise word of zero is dropped. A sample taken with the late-error input high stores 0 in place of the word. A data read while not ready returns 0 and pops nothing.
- R4: Noise is sampled once every 2^d clocks, where d is control bits 19:16.
- R5: Control bits 5 and 25:8 take the written value only on a write with bit 30 = 1. On any other write they keep their value.
- R6: Bit 30 is written 1 and then 0. It keeps reading 1 through the 15 clock edges after the clearing write and reads 0 after the 16th. On completion the core flushes the FIFO and clears status bit 2.
- R7: A hard seed error while enabled sets status bits 2 and 6, flushes the FIFO and stops sampling.
- R8: A recoverable seed error while enabled sets status bit 6 only and flushes the FIFO. Sampling continues.
- R9: Status bits 5 and 6 clear when written 0 and are unchanged when written 1. Other status bits ignore writes.
- R10: While control bit 5 is 0, status bit 1 follows the clock-error input one cycle late, and its rise sets status bit 5. While bit 5 is 1, the input is ignored.
- R11: Writing control bit 31 = 1 sets a lock that only reset clears. While locked, writes to control bits 5 and 25:8, to noise control and to health-test control are ignored.
- R12: Noise control holds bits 17:0, and its upper bits read 0. Health-test control holds all 32 bits.
- R13: The FIFO holds at most DEPTH words. Samples arriving while it is full are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low bus reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops data at 0x08) |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| noise_valid | input | 1 | Noise word present |
| noise_word | input | 32 | Noise word |
| noise_late_err | input | 1 | Late seed error: store zero for this sample |
| noise_seed_err | input | 1 | Seed-error event |
| noise_seed_hard | input | 1 | Qualifies a seed error as hard (1) or recoverable (0) |
| noise_clk_err | input | 1 | Clock-error level |

## Verification
A register write is visible on the combinational read port from the cycle after its strobe edge. A noise sample is readable one edge after it is presented, and a seed or clock error shows in status one edge after injection. The conditional-reset bit drops on the 16th edge after the clearing write. The bench drives on falling edges and samples shortly after them, and it waits exactly 15 and then 16 edges to bracket the reset completion. A scoreboard queue stores each accepted word when it is fed. A monitor compares that queue against every data read at the edge that pops it, and the queue is cleared at each flush.

// File: rtl/rng_ctrl_core.sv
module rng_ctrl_core #(
  parameter int DEPTH       = 4,
  parameter int CRST_CYCLES = 16,
  parameter int AW          = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          noise_valid,
  input  logic [31:0]   noise_word,
  input  logic          noise_late_err,
  input  logic          noise_seed_err,
  input  logic          noise_seed_hard,
  input  logic          noise_clk_err
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int KW = $clog2(CRST_CYCLES + 1);
  localparam logic [31:0] CFG_MASK = 32'h03FF_FF20;
  localparam logic [AW-1:0] A_CTRL = AW'(8'h00);
  localparam logic [AW-1:0] A_STAT = AW'(8'h04);
  localparam logic [AW-1:0] A_DATA = AW'(8'h08);
  localparam logic [AW-1:0] A_NOIS = AW'(8'h0C);
  localparam logic [AW-1:0] A_HLTH = AW'(8'h10);

  logic          en, lock, crst_bit, secs, seis, cecs, ceis;
  logic [31:0]   cfg_r;
  logic [KW-1:0] crst_cnt;
  logic [17:0]   nscr;
  logic [31:0]   htcr;
  logic [14:0]   div_cnt;
  logic [31:0]   mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] count;

  wire ctrl_wr   = bus_wr && bus_addr == A_CTRL;
  wire stat_wr   = bus_wr && bus_addr == A_STAT;
  wire crst_busy = crst_cnt != '0;
  wire crst_done = crst_busy && crst_cnt == KW'(1);
  wire seed_ev   = en && noise_seed_err;
  wire hard_ev   = seed_ev && noise_seed_hard;
  wire ced_on    = !cfg_r[5];
  wire clk_ev    = ced_on && noise_clk_err && !cecs;
  wire flush     = seed_ev || crst_done;
  wire [3:0]  div_exp = cfg_r[19:16];
  wire [14:0] div_mask = 15'((16'h1 << div_exp) - 16'h1);
  wire tick      = (div_cnt & div_mask) == div_mask;
  wire drdy      = en && !secs && count != '0;
  wire pop       = bus_rd && bus_addr == A_DATA && drdy;
  wire take      = noise_late_err || noise_word != '0;
  wire push      = tick && noise_valid && take && en && !secs && !crst_bit
                   && count != CW'(DEPTH);
  wire [31:0] push_data = noise_late_err ? 32'h0 : noise_word;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div_cnt <= '0;
    else        div_cnt <= div_cnt + 15'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; lock <= 1'b0; crst_bit <= 1'b0; crst_cnt <= '0; cfg_r <= '0;
    end else begin
      if (ctrl_wr) en <= bus_wdata[2];
      if (ctrl_wr && bus_wdata[31]) lock <= 1'b1;
      if (crst_busy) begin
        crst_cnt <= crst_cnt - KW'(1);
        if (crst_done) crst_bit <= 1'b0;
      end else if (ctrl_wr) begin
        if (bus_wdata[30]) begin
          crst_bit <= 1'b1;
          if (!lock) cfg_r <= bus_wdata & CFG_MASK;
        end else if (crst_bit) begin
          crst_cnt <= KW'(CRST_CYCLES);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secs <= 1'b0; seis <= 1'b0; cecs <= 1'b0; ceis <= 1'b0;
    end else begin
      if (hard_ev)        secs <= 1'b1;
      else if (crst_done) secs <= 1'b0;
      if (seed_ev)                        seis <= 1'b1;
      else if (stat_wr && !bus_wdata[6])  seis <= 1'b0;
      cecs <= ced_on && noise_clk_err;
      if (clk_ev)                         ceis <= 1'b1;
      else if (stat_wr && !bus_wdata[5])  ceis <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nscr <= '0; htcr <= '0;
    end else if (bus_wr && !lock) begin
      if (bus_addr == A_NOIS) nscr <= bus_wdata[17:0];
      if (bus_addr == A_HLTH) htcr <= bus_wdata;
    end
  end

  always_ff @(posedge clk)
    if (push && !flush) mem[wp] <= push_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata = cfg_r | {lock, crst_bit, 27'b0, en, 2'b0};
      A_STAT: bus_rdata = {25'b0, seis, ceis, 2'b0, secs, cecs, drdy};
      A_DATA: bus_rdata = drdy ? mem[rp] : 32'h0;
      A_NOIS: bus_rdata = {14'b0, nscr};
      A_HLTH: bus_rdata = htcr;
      default: bus_rdata = '0;
    endcase
  end

  a_r6_crst_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(crst_bit) |-> $past(crst_cnt) == KW'(1));
  a_r5_cfg_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_wr && bus_wdata[30] && !lock && !crst_busy) |=> $stable(cfg_r));
  a_r11_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> lock);
  a_r11_locked_regs: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(nscr) && $stable(htcr) && $stable(cfg_r));
  a_r7_hard_seed: assert property (@(posedge clk) disable iff (!rst_n)
    hard_ev |=> secs && seis && count == '0);
  a_r13_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r9_flag_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (seis && stat_wr && bus_wdata[6]) |=> seis);
endmodule

// File: tb/rng_ctrl_core_test.sv
module rng_ctrl_core_test;
  localparam int DEPTH = 4;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [4:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic noise_valid = 0, noise_late_err = 0, noise_seed_err = 0;
  logic noise_seed_hard = 0, noise_clk_err = 0;
  logic [31:0] noise_word = 0;
  int checks = 0, errors = 0;
  bit sb_on = 1;
  logic [31:0] exp_q[$];

  always #2 clk = ~clk;

  rng_ctrl_core #(.DEPTH(DEPTH), .CRST_CYCLES(16), .AW(5)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .noise_valid(noise_valid), .noise_word(noise_word),
    .noise_late_err(noise_late_err), .noise_seed_err(noise_seed_err),
    .noise_seed_hard(noise_seed_hard), .noise_clk_err(noise_clk_err));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (sb_on && bus_rd && bus_addr == 5'h08) begin
      logic [31:0] e;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 32'h0;
      chk("R2 data order", bus_rdata, e);
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic peek(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic feed(input logic [31:0] w, input logic late);
    @(negedge clk); noise_word = w; noise_late_err = late; noise_valid = 1;
    if ((w != 0 || late) && exp_q.size() < DEPTH) exp_q.push_back(late ? 32'h0 : w);
    @(negedge clk); noise_valid = 0; noise_late_err = 0;
  endtask

  task automatic seed(input logic hard);
    @(negedge clk); noise_seed_err = 1; noise_seed_hard = hard;
    @(negedge clk); noise_seed_err = 0; noise_seed_hard = 0;
    exp_q.delete();
  endtask

  task automatic crst(input logic [31:0] v);
    wr(5'h00, v | 32'h4000_0000);
    wr(5'h00, v);
    repeat (17) @(posedge clk);
    @(negedge clk);
    exp_q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    peek(5'h00, v); chk("R1 ctrl reset", v, 0);
    peek(5'h04, v); chk("R1 status reset", v, 0);
    peek(5'h0C, v); chk("R1 noise reset", v, 0);
    peek(5'h10, v); chk("R1 health reset", v, 0);

    wr(5'h10, 32'h1234_5678); peek(5'h10, v); chk("R12 health", v, 32'h1234_5678);
    wr(5'h0C, 32'hFFFF_FFFF); peek(5'h0C, v); chk("R12 noise width", v, 32'h0003_FFFF);

    wr(5'h00, 32'h4);
    feed(32'hA1, 0); feed(32'hB2, 0); feed(32'hC3, 0);
    peek(5'h04, v); chk("R2 ready", v, 32'h1);
    repeat (3) rd(5'h08, v);
    peek(5'h04, v); chk("R2 drained", v, 32'h0);

    feed(32'hD4, 0);
    wr(5'h00, 32'h0);
    peek(5'h04, v); chk("R2 ready needs enable", v, 32'h0);
    sb_on = 0; rd(5'h08, v); sb_on = 1;
    chk("R3 read not ready", v, 32'h0);
    wr(5'h00, 32'h4);
    peek(5'h04, v); chk("R3 no pop when not ready", v, 32'h1);
    rd(5'h08, v);

    feed(32'h0, 0);
    peek(5'h04, v); chk("R3 zero dropped", v, 32'h0);
    feed(32'h55, 1);
    peek(5'h04, v); chk("R3 late marker ready", v, 32'h1);
    rd(5'h08, v); chk("R3 late marker zero", v, 32'h0);

    for (int i = 1; i <= 6; i++) feed(32'h100 + i, 0);
    peek(5'h04, v); chk("R13 full ready", v, 32'h1);
    repeat (4) rd(5'h08, v);
    peek(5'h04, v); chk("R13 extra dropped", v, 32'h0);

    wr(5'h00, 32'h000F_0024);
    peek(5'h00, v); chk("R5 cfg ignored", v, 32'h4);
    wr(5'h00, 32'h4003_0004);
    peek(5'h00, v); chk("R5 cfg captured", v, 32'h4003_0004);
    wr(5'h00, 32'h0003_0004);
    repeat (15) @(posedge clk);
    #1 peek(5'h00, v); chk("R6 busy at edge 15", v, 32'h4003_0004);
    @(posedge clk);
    #1 peek(5'h00, v); chk("R6 clear at edge 16", v, 32'h0003_0004);

    @(negedge clk); noise_word = 32'h77; noise_valid = 1;
    repeat (16) @(negedge clk);
    noise_valid = 0;
    sb_on = 0; n = 0;
    for (int i = 0; i < 6; i++) begin
      peek(5'h04, v);
      if (v[0]) begin rd(5'h08, v); n++; end
    end
    sb_on = 1;
    chk("R4 samples per 16 clocks at d=3", n, 2);
    crst(32'h4);

    feed(32'h11, 0); feed(32'h22, 0);
    seed(0);
    peek(5'h04, v); chk("R8 soft seed flag only", v, 32'h40);
    feed(32'h33, 0);
    peek(5'h04, v); chk("R8 generation continues", v, 32'h41);
    rd(5'h08, v);
    wr(5'h04, 32'hFFFF_FFFF);
    peek(5'h04, v); chk("R9 write one keeps", v, 32'h40);
    wr(5'h04, 32'h0);
    peek(5'h04, v); chk("R9 write zero clears", v, 32'h0);

    feed(32'h44, 0);
    seed(1);
    peek(5'h04, v); chk("R7 hard seed", v, 32'h44);
    feed(32'h45, 0); exp_q.delete();
    peek(5'h04, v); chk("R7 generation stopped", v, 32'h44);
    crst(32'h4);
    peek(5'h04, v); chk("R6 seed state cleared", v, 32'h40);
    wr(5'h04, 32'h0);
    feed(32'h46, 0); rd(5'h08, v);

    @(negedge clk); noise_clk_err = 1;
    @(negedge clk);
    peek(5'h04, v); chk("R10 clock error", v, 32'h22);
    noise_clk_err = 0;
    @(negedge clk);
    peek(5'h04, v); chk("R10 state follows", v, 32'h20);
    wr(5'h04, 32'h0);
    crst(32'h24);
    @(negedge clk); noise_clk_err = 1;
    repeat (2) @(negedge clk);
    peek(5'h04, v); chk("R10 detect disabled", v, 32'h0);
    noise_clk_err = 0;

    wr(5'h00, 32'h8000_0024);
    peek(5'h00, v); chk("R11 lock set", v, 32'h8000_0024);
    wr(5'h0C, 32'h15); peek(5'h0C, v); chk("R11 noise locked", v, 32'h3FFFF);
    wr(5'h10, 32'h9); peek(5'h10, v); chk("R11 health locked", v, 32'h1234_5678);
    crst(32'h0005_0004);
    peek(5'h00, v); chk("R11 cfg locked", v, 32'h8000_0024);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule